// File: doc/BRIEF.md
# Compressed-Aware Instruction Fetch Aligner

This block sits between a 32-bit instruction bus and the decoder of a small core that mixes 16-bit and 32-bit instructions. Every bus access reads one naturally aligned word. The block cuts the returned words into halfwords and keeps up to three of them. Each cycle it offers the decoder one whole instruction, either 16 or 32 bits, together with its byte address and its size. A 32-bit instruction may begin halfway through a word. In straight-line code the upper halfword of one word is joined to the lower halfword of the next, so that case costs no cycle.

A redirect (jump or taken branch) empties the buffer, throws away any word returning in that cycle, and restarts fetch at the word that holds the target. If the target is a 32-bit instruction in the upper half of a word, two bus words are needed to collect it, which costs one cycle more than any other target.

The decoder side is a valid/ready stream. `instr_valid` never depends on `instr_ready`. While `instr_valid` is high and `instr_ready` is low, the offered instruction is held unchanged. An instruction is consumed on a clock edge where both are high. The bus side is a request with a stall input. The block throttles its own requests, so returning data can never overflow the buffer even when the decoder stops for a long time.

Top module: `cfetch_align`

## Requirements
- R1: Every bus request carries a word-aligned address, meaning its low two bits are zero. A request is accepted in a cycle where `bus_req` is high and `bus_stall` is low. The accepted word returns on `bus_rdata` with `bus_rvalid` high exactly one cycle later. The lower-addressed halfword sits in bits 15:0 of that word.
- R2: Instruction length is read from the two lowest bits of the first halfword. The value 2'b11 marks a 32-bit instruction: `instr` = {second halfword, first halfword} and `instr_is_16bit` = 0. Any other value marks a 16-bit instruction: `instr` = {16'h0000, first halfword} and `instr_is_16bit` = 1.
- R3: The stream has no gaps when there is no stall and `instr_ready` stays high. Once the first instruction after a redirect is valid, `instr_valid` stays high every cycle. This includes 32-bit instructions that straddle two words.
- R4: After reset, no request is made and `instr_valid` stays low until the first redirect. In the cycle after a redirect, `instr_valid` is low. The first request goes out in that same cycle. For an aligned target, or a 16-bit target at any halfword, the first instruction is valid two cycles after the redirect cycle.
- R5: For a 32-bit target at an address equal to 2 mod 4, the first instruction is valid three cycles after the redirect cycle.
- R6: A redirect in a cycle where `bus_rvalid` is high discards that word and every buffered halfword. The next instruction offered is the one at the new target.
- R7: While `bus_stall` is held high and the buffer is empty, `instr_valid` stays low for any length of stall and `bus_req` stays high. Fetch resumes when the stall drops.
- R8: If `instr_valid` is high, `instr_ready` is low and there is no redirect, then in the next cycle `instr_valid` is still high and `instr`, `instr_is_16bit` and `instr_pc` are unchanged.
- R9: The buffer never holds more than three halfwords. A request is issued only if at most one halfword remains after this cycle's arrival and pop. With `instr_ready` low, requests stop once a word is buffered. No instruction is lost or reordered.
- R10: `instr_pc` is the byte address of the instruction's first halfword. For the first instruction it is the redirect target. After that it advances by 2 for a 16-bit instruction and by 4 for a 32-bit instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_valid | input | 1 | Flush and restart fetch at `redirect_pc` |
| redirect_pc | input | ADDR_W | Byte address of the new target (halfword aligned) |
| bus_req | output | 1 | Fetch request |
| bus_addr | output | ADDR_W | Word-aligned fetch address |
| bus_stall | input | 1 | Bus not accepting the request this cycle |
| bus_rvalid | input | 1 | Returned word is present |
| bus_rdata | input | 32 | Returned word |
| instr_valid | output | 1 | A complete instruction is offered |
| instr_ready | input | 1 | Decoder takes the offered instruction |
| instr | output | 32 | Instruction bits, with the upper half zero for 16-bit instructions |
| instr_is_16bit | output | 1 | Offered instruction is 16 bits |
| instr_pc | output | ADDR_W | Byte address of the offered instruction |

## Verification
On every cycle, the assertions check several properties. Bus addresses must be word aligned, and a returning word must match a request that is outstanding. The buffer must never go past three halfwords, and a pop must never exceed what is held. The output must be invalid in the cycle after a redirect. A held instruction must stay stable under back-pressure, and the address must step by the consumed size. The cycle counts from a redirect to the first instruction cannot be shown by assertions and need the bench's scenarios. These cover aligned targets, misaligned 32-bit targets and 16-bit targets. The bench scenarios also show the gap-free joining of straddling instructions, the discarding of a word that returns during a redirect, and the in-order delivery after a long stall or a long decoder pause.

// File: rtl/cfa_pkg.sv
package cfa_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  typedef logic [HALF_W-1:0] half_t;

  // First halfword marks a 32-bit instruction when both low bits are set
  function automatic logic is_wide(input half_t h);
    return h[1:0] == 2'b11;
  endfunction
endpackage

// File: rtl/cfa_fetch_ctl.sv
module cfa_fetch_ctl #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect_valid,
  input  logic [ADDR_W-1:1] redirect_hw,
  input  logic              room_ok,
  input  logic              bus_stall,
  input  logic              bus_rvalid,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              data_valid,
  output logic              data_skip
);
  logic              active_q;
  logic              skip_q;
  logic              infl_q;
  logic              infl_skip_q;
  logic [ADDR_W-1:0] addr_q;
  logic              accept;

  assign bus_req    = active_q && room_ok && !redirect_valid;
  assign bus_addr   = addr_q;
  assign accept     = bus_req && !bus_stall;
  assign data_valid = bus_rvalid && infl_q;
  assign data_skip  = infl_skip_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      skip_q      <= 1'b0;
      infl_q      <= 1'b0;
      infl_skip_q <= 1'b0;
      addr_q      <= '0;
    end else if (redirect_valid) begin
      active_q    <= 1'b1;
      addr_q      <= {redirect_hw[ADDR_W-1:2], 2'b00};
      skip_q      <= redirect_hw[1];
      infl_q      <= 1'b0;
      infl_skip_q <= 1'b0;
    end else begin
      infl_q <= accept;
      if (accept) begin
        addr_q      <= addr_q + ADDR_W'(4);
        skip_q      <= 1'b0;
        infl_skip_q <= skip_q;
      end
    end
  end

  // R1
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_addr[1:0] == 2'b00);

  // R1
  rvalid_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> infl_q || $past(redirect_valid));
endmodule

// File: rtl/cfa_hw_window.sv
module cfa_hw_window
  import cfa_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int CW    = $clog2(DEPTH + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic              in_skip,
  input  logic [WORD_W-1:0] in_word,
  input  logic [1:0]        pop_n,
  output half_t             head0,
  output half_t             head1,
  output logic [CW-1:0]     avail_n,
  output logic              room_ok
);
  localparam int PAD = DEPTH + 2;

  half_t         buf_q [DEPTH];
  half_t         buf_d [DEPTH];
  half_t         win   [PAD];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] n_in;
  logic [CW-1:0] occ_next;
  half_t         in_lo;
  half_t         in_hi;

  always_comb begin
    in_lo    = in_skip ? in_word[31:16] : in_word[15:0];
    in_hi    = in_word[31:16];
    n_in     = !in_valid ? '0 : (in_skip ? CW'(1) : CW'(2));
    avail_n  = cnt_q + n_in;
    occ_next = avail_n - CW'(pop_n);
    room_ok  = occ_next <= CW'(DEPTH - 2);

    for (int i = 0; i < PAD; i++) win[i] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < cnt_q)
        win[i] = buf_q[i];
      else if (in_valid && CW'(i) == cnt_q)
        win[i] = in_lo;
      else if (in_valid && !in_skip && CW'(i) == cnt_q + CW'(1))
        win[i] = in_hi;
    end

    for (int i = 0; i < DEPTH; i++) begin
      case (pop_n)
        2'd0:    buf_d[i] = win[i];
        2'd1:    buf_d[i] = win[i+1];
        default: buf_d[i] = win[i+2];
      endcase
    end
  end

  assign head0 = win[0];
  assign head1 = win[1];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
    end else begin
      cnt_q <= occ_next;
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= buf_d[i];
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avail_n <= CW'(DEPTH));

  // R9
  pop_within_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= avail_n);
endmodule

// File: rtl/cfa_issue.sv
module cfa_issue
  import cfa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect_valid,
  input  logic [ADDR_W-1:0] redirect_pc,
  input  half_t             head0,
  input  half_t             head1,
  input  logic [CW-1:0]     avail_n,
  input  logic              instr_ready,
  output logic              instr_valid,
  output logic [WORD_W-1:0] instr,
  output logic              instr_is_16bit,
  output logic [ADDR_W-1:0] instr_pc,
  output logic [1:0]        pop_n
);
  logic              wide;
  logic [ADDR_W-1:0] pc_q;

  always_comb begin
    wide           = is_wide(head0);
    instr_is_16bit = !wide;
    instr_valid    = wide ? (avail_n >= CW'(2)) : (avail_n >= CW'(1));
    instr          = wide ? {head1, head0} : {{HALF_W{1'b0}}, head0};
    if (instr_valid && instr_ready) pop_n = wide ? 2'd2 : 2'd1;
    else                            pop_n = 2'd0;
  end

  assign instr_pc = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              pc_q <= '0;
    else if (redirect_valid) pc_q <= redirect_pc;
    else                     pc_q <= pc_q + ADDR_W'({pop_n, 1'b0});
  end

  // R4
  flush_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !instr_valid);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !instr_ready && !redirect_valid) |=>
      (instr_valid && $stable(instr) && $stable(instr_is_16bit) && $stable(instr_pc)));

  // R10
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready && !redirect_valid) |=>
      instr_pc == $past(instr_pc) + ($past(instr_is_16bit) ? ADDR_W'(2) : ADDR_W'(4)));
endmodule

// File: rtl/cfetch_align.sv
module cfetch_align
  import cfa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect_valid,
  input  logic [ADDR_W-1:0] redirect_pc,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_stall,
  input  logic              bus_rvalid,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic              instr_valid,
  input  logic              instr_ready,
  output logic [WORD_W-1:0] instr,
  output logic              instr_is_16bit,
  output logic [ADDR_W-1:0] instr_pc
);
  localparam int CW = $clog2(DEPTH + 3);

  logic          room_ok;
  logic          data_valid;
  logic          data_skip;
  half_t         head0;
  half_t         head1;
  logic [CW-1:0] avail_n;
  logic [1:0]    pop_n;

  cfa_fetch_ctl #(.ADDR_W(ADDR_W)) u_fetch (
    .clk            (clk),
    .rst_n          (rst_n),
    .redirect_valid (redirect_valid),
    .redirect_hw    (redirect_pc[ADDR_W-1:1]),
    .room_ok        (room_ok),
    .bus_stall      (bus_stall),
    .bus_rvalid     (bus_rvalid),
    .bus_req        (bus_req),
    .bus_addr       (bus_addr),
    .data_valid     (data_valid),
    .data_skip      (data_skip)
  );

  cfa_hw_window #(.DEPTH(DEPTH), .CW(CW)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (redirect_valid),
    .in_valid (data_valid),
    .in_skip  (data_skip),
    .in_word  (bus_rdata),
    .pop_n    (pop_n),
    .head0    (head0),
    .head1    (head1),
    .avail_n  (avail_n),
    .room_ok  (room_ok)
  );

  cfa_issue #(.ADDR_W(ADDR_W), .CW(CW)) u_issue (
    .clk            (clk),
    .rst_n          (rst_n),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .head0          (head0),
    .head1          (head1),
    .avail_n        (avail_n),
    .instr_ready    (instr_ready),
    .instr_valid    (instr_valid),
    .instr          (instr),
    .instr_is_16bit (instr_is_16bit),
    .instr_pc       (instr_pc),
    .pop_n          (pop_n)
  );
endmodule

// File: tb/cfetch_align_tb.sv
module cfetch_align_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redir = 1'b0;
  logic [31:0] rpc = '0;
  logic        bus_req;
  logic [31:0] bus_addr;
  logic        stall = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        instr_valid;
  logic        rdy = 1'b0;
  logic [31:0] instr;
  logic        instr_is_16bit;
  logic [31:0] instr_pc;

  logic [15:0] hw_mem [512];
  int n_chk = 0;
  int n_fail = 0;
  int r1_bad = 0;

  always #4 clk = ~clk;

  cfetch_align u_dut (
    .clk(clk), .rst_n(rst_n), .redirect_valid(redir), .redirect_pc(rpc),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_stall(stall),
    .bus_rvalid(mem_rvalid), .bus_rdata(mem_rdata),
    .instr_valid(instr_valid), .instr_ready(rdy), .instr(instr),
    .instr_is_16bit(instr_is_16bit), .instr_pc(instr_pc)
  );

  // Bus model: accepted word returns one cycle later (R1)
  always @(posedge clk) begin
    if (!rst_n) mem_rvalid <= 1'b0;
    else begin
      mem_rvalid <= bus_req && !stall;
      mem_rdata  <= {hw_mem[{bus_addr[9:2], 1'b1}], hw_mem[{bus_addr[9:2], 1'b0}]};
    end
  end

  always @(negedge clk)
    if (rst_n && bus_req && bus_addr[1:0] != 2'b00) r1_bad++;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill(input int pat);
    int i = 0;
    int k = 0;
    bit w;
    for (int n = 0; n < 512; n++) hw_mem[n] = 16'h0000;
    while (i < 510) begin
      case (pat)
        0:       w = 1'b1;
        1:       w = 1'b0;
        2:       w = (k % 3) != 0;
        default: w = (k % 2) == 1;
      endcase
      if (w) begin
        hw_mem[i]   = {i[7:0], pat[3:0], 2'b10, 2'b11};
        hw_mem[i+1] = i[15:0] ^ 16'h5A3C;
        i += 2;
      end else begin
        hw_mem[i] = {k[7:0], pat[3:0], 2'b01, 1'b0, i[0]};
        i += 1;
      end
      k++;
    end
  endtask

  // Called at the negedge of the redirect cycle (or any cycle when exp_lat is 0)
  task automatic consume(input int start, input int rmode, input bit chk_gap, input int exp_lat);
    int e = start;
    int got = 0;
    int cyc = 0;
    int first = -1;
    int gaps = 0;
    logic [15:0] h0;
    logic [31:0] ei;
    bit e16;
    @(negedge clk);
    redir = 1'b0;
    while (got < 12 && cyc < 300) begin
      cyc++;
      rdy = (rmode == 0) ? 1'b1 : cyc[0];
      if (instr_valid) begin
        if (first < 0) begin
          first = cyc;
          if (exp_lat == 3) chk(cyc == 3, "R5 misaligned 32-bit target latency", 64'(cyc), 64'(3));
          else if (exp_lat == 2) chk(cyc == 2, "R4 redirect latency", 64'(cyc), 64'(2));
        end
        if (rdy) begin
          h0 = hw_mem[e];
          if (h0[1:0] == 2'b11) begin ei = {hw_mem[e+1], h0}; e16 = 1'b0; end
          else begin ei = {16'h0000, h0}; e16 = 1'b1; end
          chk(instr == ei && instr_is_16bit == e16 && instr_pc == 32'(2 * e),
              "R2 R10 instruction, size and address",
              {instr_pc, instr}, {32'(2 * e), ei});
          e += e16 ? 1 : 2;
          got++;
        end
      end else if (first >= 0 && chk_gap) gaps++;
      @(negedge clk);
    end
    rdy = 1'b0;
    chk(got == 12, "R9 stream delivered in order", 64'(got), 64'(12));
    if (chk_gap) chk(gaps == 0, "R3 no gaps in straight-line stream", 64'(gaps), 64'(0));
  endtask

  // pattern, start halfword, ready mode, expected cycles to first instruction
  localparam int TBL [6][4] = '{
    '{0,   8, 0, 2},
    '{1,  21, 0, 2},
    '{2,   0, 0, 2},
    '{2,   1, 0, 3},
    '{3,   7, 1, 3},
    '{0, 100, 1, 2}
  };

  initial begin
    int bad;
    int reqs;
    logic [31:0] hold_i;
    logic [31:0] hold_pc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk(!instr_valid, "R4 reset: no instruction before redirect", 64'(instr_valid), 64'(0));
      chk(!bus_req, "R4 reset: no request before redirect", 64'(bus_req), 64'(0));
    end

    for (int t = 0; t < 6; t++) begin
      fill(TBL[t][0]);
      @(negedge clk);
      redir = 1'b1;
      rpc = 32'(2 * TBL[t][1]);
      consume(TBL[t][1], TBL[t][2], TBL[t][2] == 0, TBL[t][3]);
    end

    // R6: redirect while a word is returning
    fill(2);
    @(negedge clk); redir = 1'b1; rpc = 32'd0;
    @(negedge clk); redir = 1'b0;
    @(negedge clk);
    chk(mem_rvalid == 1'b1, "R6 word returning during redirect", 64'(mem_rvalid), 64'(1));
    redir = 1'b1; rpc = 32'd12;
    consume(6, 0, 1'b1, 2);

    // R7: long stall with empty buffer
    fill(2);
    @(negedge clk); stall = 1'b1; redir = 1'b1; rpc = 32'd6;
    @(negedge clk); redir = 1'b0;
    bad = 0; reqs = 0;
    repeat (40) begin
      @(negedge clk);
      if (instr_valid) bad++;
      if (bus_req) reqs++;
    end
    chk(bad == 0, "R7 output invalid during stall", 64'(bad), 64'(0));
    chk(reqs == 40, "R7 request held during stall", 64'(reqs), 64'(40));
    stall = 1'b0;
    consume(3, 0, 1'b0, 0);

    // R8 / R9: decoder back-pressure
    fill(0);
    @(negedge clk); redir = 1'b1; rpc = 32'd0; rdy = 1'b0;
    @(negedge clk); redir = 1'b0;
    repeat (3) @(negedge clk);
    chk(instr_valid, "R8 instruction offered under back-pressure", 64'(instr_valid), 64'(1));
    chk(!bus_req, "R9 requests stop while buffer is held", 64'(bus_req), 64'(0));
    hold_i = instr; hold_pc = instr_pc;
    bad = 0;
    repeat (4) begin
      @(negedge clk);
      if (!instr_valid || instr != hold_i || instr_pc != hold_pc || bus_req) bad++;
    end
    chk(bad == 0, "R8 held instruction stable", 64'(bad), 64'(0));
    consume(0, 0, 1'b0, 0);

    chk(r1_bad == 0, "R1 word-aligned requests", 64'(r1_bad), 64'(0));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule